// File: doc/BRIEF.md
# Split-Bank Interrupt Mask and Vector Unit

This unit gathers sixteen edge-triggered interrupt request lines, split into a low bank (lines 0 to 7) and a high bank (lines 8 to 15). Each bank has its own small byte port. Software uses it to disable lines and to retire requests. A rising edge on a request line latches a pending bit. Only pending lines whose enable bit is set take part in the combined interrupt output and in the vector.

The enable mask is written inverted: a 1 in the written byte turns a line off. An end-of-interrupt write clears every latched request of one bank at once and leaves the other bank alone. The vector word gives the lowest-numbered line that is both pending and enabled. It reads 0 when no such line exists, so the combined output is what tells "line 0" apart from "none".

A separate cause word serves fifteen level-type local sources. It is sampled once per clock and reports the lowest active source as (index + 1) shifted left by two, or 0 when none is active.

Top module: `irq_bank_vector`

## Requirements
- R1: After reset the enable mask is 0xFFFF, nothing is pending, `irq_out` is 0, and both `vec_rdata` and `cause_rdata` read 0.
- R2: A write with `bank_sel`=0 and `bank_off`=1 sets enable bits 7:0 to the bitwise inverse of `bank_wdata`, effective from the next clock. Enable bits 15:8 are unchanged.
- R3: A write with `bank_sel`=1 and `bank_off`=1 sets enable bits 15:8 to the bitwise inverse of `bank_wdata`, effective from the next clock. Enable bits 7:0 are unchanged.
- R4: While `bank_rd` is high with `bank_off`=1, `bank_rdata` shows the full 16-bit enable mask in the same cycle (bit n enables line n), whichever bank is selected.
- R5: A write with `bank_off`=0 clears all pending bits of the selected bank and leaves the other bank's pending bits unchanged. A rising edge that arrives in the same cycle as that write stays pending.
- R6: `vec_rdata` equals the index of the lowest set bit of (pending AND enable), zero-extended to 32 bits, or 0 if that set is empty.
- R7: A request line that was low at one clock and high at the next sets its pending bit. A line that stays high does not set it again after it has been cleared.
- R8: `irq_out` is 1 exactly when at least one line is both pending and enabled.
- R9: `lcl_src` is registered once. `cause_rdata` is then ((i + 1) << 2), where i is the lowest set bit of the registered value, or 0 when that value is 0.
- R10: Writes with `bank_off` of 2 or 3 change neither the mask nor the pending bits. Reads at offsets 0, 2 and 3, and whenever `bank_rd` is low, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_line | input | 16 | Edge-triggered request lines; bit n is line n |
| lcl_src | input | 15 | Level-type local sources for the cause word |
| bank_sel | input | 1 | Bank port select: 0 low bank, 1 high bank |
| bank_off | input | 2 | Byte offset in the bank port: 0 end-of-interrupt, 1 mask |
| bank_wr | input | 1 | Write strobe for the bank port |
| bank_rd | input | 1 | Read strobe for the bank port |
| bank_wdata | input | 8 | Write byte |
| bank_rdata | output | 16 | Read data (enable mask at offset 1, else 0) |
| vec_rdata | output | 32 | Lowest pending and enabled line, or 0 |
| cause_rdata | output | 32 | Scaled local cause code |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The per-line results take effect at the first rising edge after the stimulus. This covers a latched edge, a mask write and an end-of-interrupt write, after which `vec_rdata`, `irq_out` and the mask change. The cause word likewise follows `lcl_src` one edge later. The bench drives every stimulus at a falling edge and compares at the next falling edge, half a period after the edge that applied it. Mask reads are combinational, so they are compared one nanosecond after the strobe is raised, with no clock edge in between.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int OFF_W = 2;
  localparam logic [OFF_W-1:0] OFF_EOI  = 2'd0;
  localparam logic [OFF_W-1:0] OFF_MASK = 2'd1;

  // Vector word: plain zero-extended index, zero when nothing qualifies.
  function automatic logic [31:0] vector_word(input logic hit, input logic [7:0] idx);
    return hit ? {24'b0, idx} : 32'b0;
  endfunction

  // Cause word: (index + 1) scaled by four, zero when no source is active.
  function automatic logic [31:0] cause_word(input logic hit, input logic [7:0] idx);
    logic [9:0] code;
    code = {2'b0, idx} + 10'd1;
    return hit ? {20'b0, code, 2'b00} : 32'b0;
  endfunction
endpackage

// File: rtl/irqv_bank.sv
module irqv_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic         eoi,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] en,
  output logic [W-1:0] rise
);
  logic [W-1:0] req_q;

  assign rise = req & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
      en    <= '1;
    end else begin
      req_q <= req;
      if (eoi) pend <= rise;
      else     pend <= pend | rise;
      if (mask_we) en <= ~wdata;
    end
  end
endmodule

// File: rtl/irqv_scan.sv
module irqv_scan #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  bits,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_bank_vector.sv
module irq_bank_vector
  import irqv_pkg::*;
#(
  parameter int BANK_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int LCL_W     = 15,
  localparam int LINES    = BANK_W * NUM_BANKS,
  localparam int SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_line,
  input  logic [LCL_W-1:0]  lcl_src,
  input  logic [SEL_W-1:0]  bank_sel,
  input  logic [OFF_W-1:0]  bank_off,
  input  logic              bank_wr,
  input  logic              bank_rd,
  input  logic [BANK_W-1:0] bank_wdata,
  output logic [LINES-1:0]  bank_rdata,
  output logic [31:0]       vec_rdata,
  output logic [31:0]       cause_rdata,
  output logic              irq_out
);
  localparam int VIW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int CIW = (LCL_W > 1) ? $clog2(LCL_W) : 1;

  logic [LINES-1:0]     pend, en_mask, rise, active;
  logic [NUM_BANKS-1:0] eoi, mask_we;
  logic [LCL_W-1:0]     lcl_q;
  logic                 vec_hit, cause_hit;
  logic [VIW-1:0]       vec_idx;
  logic [CIW-1:0]       cause_idx;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign eoi[b]     = bank_wr && (bank_off == OFF_EOI)  && (bank_sel == SEL_W'(b));
    assign mask_we[b] = bank_wr && (bank_off == OFF_MASK) && (bank_sel == SEL_W'(b));

    irqv_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (irq_line[b*BANK_W +: BANK_W]),
      .eoi     (eoi[b]),
      .mask_we (mask_we[b]),
      .wdata   (bank_wdata),
      .pend    (pend[b*BANK_W +: BANK_W]),
      .en      (en_mask[b*BANK_W +: BANK_W]),
      .rise    (rise[b*BANK_W +: BANK_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lcl_q <= '0;
    else        lcl_q <= lcl_src;
  end

  assign active = pend & en_mask;

  irqv_scan #(.N(LINES), .IW(VIW)) u_vec (
    .bits (active),
    .hit  (vec_hit),
    .idx  (vec_idx)
  );

  irqv_scan #(.N(LCL_W), .IW(CIW)) u_cause (
    .bits (lcl_q),
    .hit  (cause_hit),
    .idx  (cause_idx)
  );

  assign vec_rdata   = vector_word(vec_hit, 8'(vec_idx));
  assign cause_rdata = cause_word(cause_hit, 8'(cause_idx));
  assign irq_out     = vec_hit;
  assign bank_rdata  = (bank_rd && bank_off == OFF_MASK) ? en_mask : '0;
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter int BANK_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int LCL_W     = 15,
  localparam int LINES    = BANK_W * NUM_BANKS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bank_rd,
  input logic [1:0]           bank_off,
  input logic [BANK_W-1:0]    bank_wdata,
  input logic [LINES-1:0]     bank_rdata,
  input logic [31:0]          vec_rdata,
  input logic [31:0]          cause_rdata,
  input logic                 irq_out,
  input logic [LINES-1:0]     en_mask,
  input logic [LINES-1:0]     pend,
  input logic [LINES-1:0]     rise,
  input logic [NUM_BANKS-1:0] eoi,
  input logic [NUM_BANKS-1:0] mask_we,
  input logic [LCL_W-1:0]     lcl_q
);
  AST_RESET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (en_mask == '1)); // R1
  AST_MASK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we[0] |=> (en_mask[BANK_W-1:0] == ~$past(bank_wdata))); // R2
  AST_MASK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we[1] |=> (en_mask[LINES-1:BANK_W] == ~$past(bank_wdata))); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we == '0) |=> $stable(en_mask)); // R10
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_rd || bank_off != 2'd1) |-> (bank_rdata == '0)); // R10
  AST_EOI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    eoi[0] |=> ((pend[BANK_W-1:0] & ~$past(rise[BANK_W-1:0])) == '0)); // R5
  AST_EOI_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi[0] && !eoi[1]) |=>
      (pend[LINES-1:BANK_W] == $past(pend[LINES-1:BANK_W] | rise[LINES-1:BANK_W]))); // R5
  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend & $past(rise)) == $past(rise))); // R7
  AST_VEC_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> (vec_rdata == '0)); // R6
  AST_OUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(rise) != '0 || $past(mask_we) != '0)); // R8
  AST_CAUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_q == '0) |-> (cause_rdata == '0)); // R9
  AST_CAUSE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cause_rdata[1:0] == 2'b00); // R9
endmodule

bind irq_bank_vector irqv_chk #(
  .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .LCL_W(LCL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_rd(bank_rd), .bank_off(bank_off),
  .bank_wdata(bank_wdata), .bank_rdata(bank_rdata), .vec_rdata(vec_rdata),
  .cause_rdata(cause_rdata), .irq_out(irq_out), .en_mask(en_mask),
  .pend(pend), .rise(rise), .eoi(eoi), .mask_we(mask_we), .lcl_q(lcl_q)
);

// File: tb/test_irq_bank_vector.sv
`timescale 1ns/1ps
module test_irq_bank_vector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_line = '0;
  logic [14:0] lcl_src = '0;
  logic        bank_sel = 1'b0;
  logic [1:0]  bank_off = '0;
  logic        bank_wr = 1'b0;
  logic        bank_rd = 1'b0;
  logic [7:0]  bank_wdata = '0;
  logic [15:0] bank_rdata;
  logic [31:0] vec_rdata, cause_rdata;
  logic        irq_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_bank_vector i_irq_bank_vector (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .lcl_src(lcl_src),
    .bank_sel(bank_sel), .bank_off(bank_off), .bank_wr(bank_wr), .bank_rd(bank_rd),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata), .vec_rdata(vec_rdata),
    .cause_rdata(cause_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [1:0] off, input logic [7:0] d);
    @(negedge clk);
    bank_sel = sel; bank_off = off; bank_wdata = d; bank_wr = 1'b1;
    @(negedge clk);
    bank_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic sel, input logic [1:0] off, output logic [15:0] v);
    bank_sel = sel; bank_off = off; bank_rd = 1'b1;
    #1 v = bank_rdata;
    bank_rd = 1'b0;
  endtask

  task automatic set_lines(input logic [15:0] v);
    @(negedge clk);
    irq_line = v;
    @(negedge clk);
  endtask

  // index of an isolated single bit, by log2
  function automatic int bit_pos(input int iso);
    return $clog2(iso);
  endfunction

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(1'b0, 2'd1, rv); chk("R1 mask", 32'(rv), 32'hFFFF);
    chk("R1 vec", vec_rdata, 0);
    chk("R1 irq_out", 32'(irq_out), 0);
    chk("R1 cause", cause_rdata, 0);

    // R7 / R6 / R8 / R5: each line on its own
    for (int i = 0; i < 16; i++) begin
      set_lines(16'(1 << i));
      chk("R6 single line vector", vec_rdata, 32'(i));
      chk("R8 single line irq_out", 32'(irq_out), 1);
      bus_wr(1'(i / 8), 2'd0, 8'h20);
      chk("R5 eoi clears", 32'(irq_out), 0);
      chk("R5 eoi vector", vec_rdata, 0);
      @(negedge clk);
      chk("R7 held line no relatch", 32'(irq_out), 0);
      set_lines(16'h0);
    end

    // R5: bank independence and same-cycle edge
    set_lines(16'h1008);
    chk("R6 two banks lowest", vec_rdata, 3);
    @(negedge clk);
    irq_line = 16'h1028;
    bank_sel = 1'b0; bank_off = 2'd0; bank_wr = 1'b1;
    @(negedge clk);
    bank_wr = 1'b0;
    chk("R5 same-cycle edge kept", vec_rdata, 5);
    bus_wr(1'b0, 2'd0, 8'h20);
    chk("R5 high bank untouched", vec_rdata, 12);
    bus_wr(1'b1, 2'd0, 8'h20);
    chk("R5 high bank cleared", 32'(irq_out), 0);
    set_lines(16'h0);

    // R2 / R4 / R6: low mask sweep, all lines pending, high bank masked
    set_lines(16'hFFFF);
    bus_wr(1'b1, 2'd1, 8'hFF);
    for (int m = 0; m < 256; m++) begin
      int iso;
      bus_wr(1'b0, 2'd1, 8'(m));
      bus_rd(1'b0, 2'd1, rv); chk("R2 R4 low port read", 32'(rv), 32'(16'({8'h00, ~8'(m)})));
      bus_rd(1'b1, 2'd1, rv); chk("R4 high port read", 32'(rv), 32'(16'({8'h00, ~8'(m)})));
      iso = (m + 1) & ~m & 9'h1FF;
      chk("R6 low mask vector", vec_rdata, (m == 255) ? 0 : 32'(bit_pos(iso)));
      chk("R8 low mask irq_out", 32'(irq_out), (m == 255) ? 0 : 1);
    end

    // R3 / R6: high mask sweep, low bank masked
    for (int m = 0; m < 256; m++) begin
      int iso;
      bus_wr(1'b1, 2'd1, 8'(m));
      bus_rd(1'b1, 2'd1, rv); chk("R3 R4 high mask read", 32'(rv), 32'(16'({~8'(m), 8'h00})));
      iso = (m + 1) & ~m & 9'h1FF;
      chk("R3 high mask vector", vec_rdata, (m == 255) ? 0 : 32'(8 + bit_pos(iso)));
    end

    // R10: unmapped offsets
    bus_wr(1'b0, 2'd2, 8'h00);
    bus_wr(1'b1, 2'd3, 8'h00);
    bus_wr(1'b0, 2'd3, 8'h00);
    chk("R10 unmapped write no unmask", 32'(irq_out), 0);
    bus_rd(1'b0, 2'd1, rv); chk("R10 mask unchanged", 32'(rv), 0);
    bus_rd(1'b0, 2'd0, rv); chk("R10 read off0", 32'(rv), 0);
    bus_rd(1'b1, 2'd2, rv); chk("R10 read off2", 32'(rv), 0);
    bus_rd(1'b0, 2'd3, rv); chk("R10 read off3", 32'(rv), 0);
    bus_wr(1'b1, 2'd1, 8'hFE);
    chk("R10 pending survived", vec_rdata, 8);
    bus_wr(1'b0, 2'd1, 8'h00);
    chk("R6 all enabled line 0", vec_rdata, 0);
    chk("R8 line 0 irq_out", 32'(irq_out), 1);

    // R9: exhaustive cause sweep
    for (int v = 0; v < 32768; v++) begin
      int iso;
      @(negedge clk);
      lcl_src = 15'(v);
      @(negedge clk);
      iso = v & (-v);
      chk("R9 cause", cause_rdata, (v == 0) ? 0 : 32'((bit_pos(iso) + 1) * 4));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule